// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block runs next to the bit engine of an I2C master and decides, one bit at a time, whether that master still holds the bus while other masters may be transmitting at the same moment. Ownership is never granted by a central master or a fixed priority. It is kept only by the master whose released bits survive the wired-AND of the SDA line. The monitor reads the raw SDA and SCL lines through two-flop synchronizers. It compares the line once per bit, a fixed number of system clocks after the synchronized SCL rises. It then reports the outcome to the bit engine.

On a loss it emits a one-cycle pulse and sets a sticky flag. It also gates the master's SDA pull-down enable, so the line follows the winning master for the rest of the transfer. It also watches for collisions that arbitration cannot settle. These are a repeated START or a STOP meeting another master's data bit, and a repeated START meeting a STOP. Each such collision raises an illegal-arbitration pulse in place of a normal loss.

The bit engine marks each bit it sends with one of three flags: ordinary bit (address, master code or data), repeated START, or STOP. When no flag is set, or while it is receiving or acknowledging (transmit-active low), no comparison is made. Slave traffic therefore never takes part.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, `lost_pulse`, `lost_flag` and `illegal_err` are 0, and `sda_pull` equals `sda_oe`.
- R2: On an ordinary bit with `tx_active` high, if the master's bit is 1 and the synchronized SDA reads 0 at the sample point (SAMPLE_DLY clocks after the synchronized SCL rises), `lost_pulse` is high for exactly one cycle and `lost_flag` becomes 1.
- R3: No loss is reported when the master's bit is 0, or when the sampled SDA matches a released 1.
- R4: While `lost_flag` is 1, `sda_pull` is 0 whatever `sda_oe` is, and no further `lost_pulse` occurs.
- R5: `lost_flag` returns to 0 on a `clr_lost` cycle, or when a STOP condition (SDA rising while SCL is high) appears on the bus.
- R6: While `tx_active` is 0, neither `lost_pulse` nor `illegal_err` is raised.
- R7: During an ordinary bit, a START or STOP condition seen on the bus raises `illegal_err`, and no loss is reported for that bit.
- R8: During a repeated-START bit or a STOP bit, SDA read as 0 at the sample point raises `illegal_err`. For a STOP bit, the bit engine releases SDA before the sample point.
- R9: A bus STOP condition during the master's repeated-START bit raises `illegal_err`, and so does a bus START condition during its STOP bit.
- R10: `illegal_err` pulses at most once per SCL high period. The master's own repeated START or STOP, with no other master active, raises no error.
- R11: Over a bit sequence sent MSB first, the loss is reported at the first bit where the master released SDA and another master pulled it low. The bits before that one raise no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| tx_active | input | 1 | Bit engine is transmitting; enables all checks |
| bit_val | input | 1 | Bit the master intends to send on an ordinary bit |
| sda_oe | input | 1 | Master's SDA pull-down request (1 = pull low) |
| mark_data | input | 1 | Current bit is an ordinary address or data bit |
| mark_rstart | input | 1 | Current bit is a repeated START |
| mark_stop | input | 1 | Current bit is a STOP |
| clr_lost | input | 1 | Clears the sticky lost flag |
| sda_pull | output | 1 | Gated pull-down to the SDA pad (1 = pull low) |
| lost_pulse | output | 1 | One-cycle pulse when arbitration is lost |
| lost_flag | output | 1 | Sticky arbitration-lost flag |
| illegal_err | output | 1 | One-cycle pulse on a forbidden collision |

## Verification
The embedded properties check on every cycle that sampling happens once and only while SCL is high, and that a loss pulse never repeats while the flag is held. They also check that a clear drops the flag, that loss and illegal pulses never coincide, that at most one illegal pulse occurs per bit, and that an idle bit engine causes no report. Only the bench scenarios can show the arbitration outcome itself. This covers which bit of a contested byte loses, that the released line then mirrors the winner, and that each of the six collision patterns is told apart from a normal loss. It also covers that the master's own repeated START and STOP are not flagged.

// File: rtl/i2c_arb_pkg.sv
// Shared types for the arbitration monitor.
// Assumes: one bit kind is active at a time; events are single-cycle.
package i2c_arb_pkg;
    typedef enum logic [1:0] {
        BIT_NONE   = 2'd0,
        BIT_DATA   = 2'd1,
        BIT_RSTART = 2'd2,
        BIT_STOP   = 2'd3
    } bit_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/line_sync.sv
// Multi-stage synchronizer for asynchronous line inputs.
// Assumes STAGES >= 2; the reset value matches an idle (high) bus.
module line_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int TOTAL = WIDTH * STAGES;

    logic [TOTAL-1:0] chain;

    // Shift raw inputs through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[TOTAL-WIDTH-1:0], d};
    end

    assign q = chain[TOTAL-1 -: WIDTH];
endmodule

// File: rtl/sample_timer.sv
// Produces one sample strobe per SCL high period, SAMPLE_DLY clocks
// after the synchronized SCL rises. No strobe if SCL falls earlier.
// Assumes SAMPLE_DLY >= 1.
module sample_timer #(
    parameter int SAMPLE_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    output logic strobe
);
    localparam int CNT_SAT = SAMPLE_DLY + 1;
    localparam int CW      = $clog2(CNT_SAT + 1);

    logic [CW-1:0] cnt;
    logic          scl_q;

    // Count cycles of SCL high, saturating past the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (!scl_s)                cnt <= '0;
        else if (cnt != CW'(CNT_SAT))   cnt <= cnt + 1'b1;
    end

    // Keep the previous SCL level for the assertion below.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_s;
    end

    assign strobe = scl_s && (cnt == CW'(SAMPLE_DLY));

    a_r2_strobe_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (scl_s && scl_q));
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/bus_cond_detect.sv
// Detects START (SDA falling) and STOP (SDA rising) conditions while
// the synchronized SCL stays high. Assumes synchronized inputs.
module bus_cond_detect
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sda_s,
    input  logic     scl_s,
    output bus_evt_t evt
);
    logic sda_d;
    logic scl_d;

    // Delay the synchronized lines by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s;
            scl_d <= scl_s;
        end
    end

    // Qualify SDA edges with SCL high on both cycles.
    always_comb begin
        evt.start = scl_s && scl_d && sda_d && !sda_s;
        evt.stop  = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/arb_core.sv
// Decides loss and illegal collisions for each transmitted bit and
// holds the sticky lost flag. Assumes strobe and events are one-cycle.
module arb_core
    import i2c_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_active,
    input  bit_kind_e kind,
    input  logic      bit_val,
    input  logic      sda_s,
    input  logic      scl_s,
    input  logic      strobe,
    input  bus_evt_t  evt,
    input  logic      clr_lost,
    output logic      lost_pulse,
    output logic      lost_flag,
    output logic      illegal_err
);
    logic armed;
    logic illegal_seen;
    logic ctl_bit;
    logic illegal_now;
    logic loss_now;

    // Checks run only for our own transmission, before loss or error.
    assign armed   = tx_active && !lost_flag && !illegal_seen;
    assign ctl_bit = (kind == BIT_RSTART) || (kind == BIT_STOP);

    // Classify the current cycle's collision or loss.
    always_comb begin
        illegal_now = 1'b0;
        if (armed) begin
            if (kind == BIT_DATA && (evt.start || evt.stop))  illegal_now = 1'b1;
            if (ctl_bit && strobe && !sda_s)                  illegal_now = 1'b1;
            if (kind == BIT_RSTART && evt.stop)               illegal_now = 1'b1;
            if (kind == BIT_STOP && evt.start)                illegal_now = 1'b1;
        end
        loss_now = armed && (kind == BIT_DATA) && strobe && bit_val
                   && !sda_s && !illegal_now;
    end

    // Sticky lost flag: a new loss wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     lost_flag <= 1'b0;
        else if (loss_now)              lost_flag <= 1'b1;
        else if (clr_lost || evt.stop)  lost_flag <= 1'b0;
    end

    // One-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_pulse  <= 1'b0;
            illegal_err <= 1'b0;
        end else begin
            lost_pulse  <= loss_now;
            illegal_err <= illegal_now;
        end
    end

    // Remember an error within the current SCL high period.
    always_ff @(posedge clk) begin
        if (!rst_n)      illegal_seen <= 1'b0;
        else if (!scl_s) illegal_seen <= 1'b0;
        else             illegal_seen <= illegal_seen || illegal_now;
    end

    a_r4_no_repulse: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse |-> (lost_flag && !$past(lost_flag)));
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_lost) && !lost_pulse) |-> !lost_flag);
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lost_pulse && illegal_err));
    a_r10_one_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |=> !illegal_err);
endmodule

// File: rtl/i2c_arb_monitor.sv
// Top of the arbitration monitor: synchronizes the lines, times the
// sample point, detects bus conditions and gates the SDA pull-down.
// Assumes at most one of the bit-kind marks is set at a time.
module i2c_arb_monitor
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_DLY  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    input  logic tx_active,
    input  logic bit_val,
    input  logic sda_oe,
    input  logic mark_data,
    input  logic mark_rstart,
    input  logic mark_stop,
    input  logic clr_lost,
    output logic sda_pull,
    output logic lost_pulse,
    output logic lost_flag,
    output logic illegal_err
);
    logic [1:0] lines_s;
    logic       sda_s;
    logic       scl_s;
    logic       strobe;
    bus_evt_t   evt;
    bit_kind_e  kind;

    line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sda_in, scl_in}),
        .q     (lines_s)
    );
    assign sda_s = lines_s[1];
    assign scl_s = lines_s[0];

    sample_timer #(.SAMPLE_DLY(SAMPLE_DLY)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (scl_s),
        .strobe (strobe)
    );

    bus_cond_detect u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .sda_s (sda_s),
        .scl_s (scl_s),
        .evt   (evt)
    );

    // Decode bit-engine marks into one kind; STOP has highest priority.
    always_comb begin
        if (mark_stop)        kind = BIT_STOP;
        else if (mark_rstart) kind = BIT_RSTART;
        else if (mark_data)   kind = BIT_DATA;
        else                  kind = BIT_NONE;
    end

    arb_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active   (tx_active),
        .kind        (kind),
        .bit_val     (bit_val),
        .sda_s       (sda_s),
        .scl_s       (scl_s),
        .strobe      (strobe),
        .evt         (evt),
        .clr_lost    (clr_lost),
        .lost_pulse  (lost_pulse),
        .lost_flag   (lost_flag),
        .illegal_err (illegal_err)
    );

    // Release SDA once arbitration is lost.
    assign sda_pull = sda_oe && !lost_flag;

    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_active) |-> (!lost_pulse && !illegal_err));
endmodule

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic tx_active = 1'b0;
    logic bit_val = 1'b0;
    logic sda_oe = 1'b0;
    logic mark_data = 1'b0;
    logic mark_rstart = 1'b0;
    logic mark_stop = 1'b0;
    logic clr_lost = 1'b0;
    logic other_pull = 1'b0;
    logic sda_in;
    logic sda_pull, lost_pulse, lost_flag, illegal_err;

    int n_checks = 0;
    int n_fail = 0;
    int n_lost = 0;
    int n_ill = 0;

    localparam int K_DATA = 1, K_RSTART = 2, K_STOP = 3;

    always #5 clk = ~clk;

    assign sda_in = ~(sda_pull | other_pull);

    i2c_arb_monitor uut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
        .tx_active(tx_active), .bit_val(bit_val), .sda_oe(sda_oe),
        .mark_data(mark_data), .mark_rstart(mark_rstart), .mark_stop(mark_stop),
        .clr_lost(clr_lost), .sda_pull(sda_pull), .lost_pulse(lost_pulse),
        .lost_flag(lost_flag), .illegal_err(illegal_err)
    );

    // Count result pulses seen at the ports.
    always @(posedge clk) begin
        if (rst_n) begin
            if (lost_pulse)  n_lost = n_lost + 1;
            if (illegal_err) n_ill  = n_ill + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One bit on the bus; oth_tog toggles the other master at cycle 2 or 14 of SCL high.
    task automatic run_bit(input int kind, input bit mybit, input bit oth_low, input int oth_tog);
        @(negedge clk) scl_in = 1'b0;
        repeat (4) @(negedge clk);
        mark_data   = (kind == K_DATA);
        mark_rstart = (kind == K_RSTART);
        mark_stop   = (kind == K_STOP);
        bit_val     = mybit;
        sda_oe      = (kind == K_DATA) ? ~mybit : (kind == K_STOP);
        other_pull  = oth_low;
        repeat (6) @(negedge clk);
        scl_in = 1'b1;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (c == 2) begin
                if (kind == K_STOP) sda_oe = 1'b0;
                if (oth_tog == 2) other_pull = ~other_pull;
            end
            if (c == 14) begin
                if (kind == K_RSTART) sda_oe = 1'b1;
                if (oth_tog == 14) other_pull = ~other_pull;
            end
        end
    endtask

    task automatic clear_lost();
        @(negedge clk) clr_lost = 1'b1;
        @(negedge clk) clr_lost = 1'b0;
        other_pull = 1'b0;
    endtask

    // Vector fields: {tx_active, my bit, other pulls low, expected loss}
    localparam logic [3:0] VEC [6] = '{
        4'b1111, 4'b1100, 4'b1010, 4'b1000, 4'b0110, 4'b0000
    };

    // Collision fields: kind, my bit, other low, toggle cycle
    task automatic collide(input int kind, input bit mybit, input bit oth_low, input int tog,
                           input string tag);
        int l0, i0;
        clear_lost();
        tx_active = 1'b1;
        l0 = n_lost; i0 = n_ill;
        run_bit(kind, mybit, oth_low, tog);
        check(n_ill - i0 == 1, {tag, " illegal count"}, n_ill - i0, 1);
        check(n_lost - l0 == 0, {tag, " no loss"}, n_lost - l0, 0);
    endtask

    initial begin
        int l0, i0;
        logic [7:0] mine, theirs;
        repeat (3) @(negedge clk);
        // R1: reset state
        sda_oe = 1'b1;
        @(negedge clk);
        check(lost_flag == 1'b0, "R1 lost_flag", lost_flag, 0);
        check(lost_pulse == 1'b0 && illegal_err == 1'b0, "R1 pulses", lost_pulse | illegal_err, 0);
        check(sda_pull == 1'b1, "R1 sda_pull follows sda_oe", sda_pull, 1);
        sda_oe = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R6: single-bit vectors
        foreach (VEC[v]) begin
            clear_lost();
            tx_active = VEC[v][3];
            l0 = n_lost; i0 = n_ill;
            run_bit(K_DATA, VEC[v][2], VEC[v][1], 0);
            check(lost_flag == VEC[v][0], "R2/R3 vector lost_flag", lost_flag, VEC[v][0]);
            check(n_lost - l0 == int'(VEC[v][0]), "R2 single pulse", n_lost - l0, VEC[v][0]);
            if (!VEC[v][3]) check(n_ill - i0 == 0, "R6 no illegal when idle", n_ill - i0, 0);
        end

        // R11 R4: contested byte, MSB first; first released-1 vs pulled-0 is bit 2
        clear_lost();
        tx_active = 1'b1;
        mine = 8'hA5; theirs = 8'hA1;
        l0 = n_lost;
        for (int i = 7; i >= 0; i--) begin
            run_bit(K_DATA, mine[i], ~theirs[i], 0);
            check(lost_flag == (i <= 2), "R11 lost at first differing bit", lost_flag, i <= 2);
            if (i < 2) begin
                check(sda_pull == 1'b0, "R4 SDA released after loss", sda_pull, 0);
                check(sda_in == theirs[i], "R4 SDA mirrors winner", sda_in, theirs[i]);
            end
        end
        check(n_lost - l0 == 1, "R4 one loss pulse per byte", n_lost - l0, 1);

        // R5: clear input and bus STOP
        clear_lost();
        check(lost_flag == 1'b0, "R5 clr_lost clears", lost_flag, 0);
        run_bit(K_DATA, 1'b1, 1'b1, 0);
        check(lost_flag == 1'b1, "R5 setup loss", lost_flag, 1);
        i0 = n_ill;
        other_pull = 1'b0;
        run_bit(K_STOP, 1'b0, 1'b0, 0);
        check(lost_flag == 1'b0, "R5 bus STOP clears", lost_flag, 0);
        check(n_ill - i0 == 0, "R10 own STOP not flagged", n_ill - i0, 0);

        // R10: own repeated START alone
        clear_lost();
        i0 = n_ill;
        run_bit(K_RSTART, 1'b0, 1'b0, 0);
        check(n_ill - i0 == 0, "R10 own repeated START not flagged", n_ill - i0, 0);

        // R7: our data bit meets another START / STOP
        collide(K_DATA, 1'b1, 1'b0, 14, "R7 data vs START");
        collide(K_DATA, 1'b1, 1'b1, 2, "R7 data vs STOP");
        // R8: control bit meets data 0
        collide(K_RSTART, 1'b0, 1'b1, 0, "R8 repeated START vs data");
        collide(K_STOP, 1'b0, 1'b1, 0, "R8 STOP vs data");
        // R9: repeated START vs STOP, both directions
        collide(K_RSTART, 1'b0, 1'b1, 2, "R9 repeated START vs STOP");
        collide(K_STOP, 1'b0, 1'b0, 14, "R9 STOP vs START");

        // R6: collision pattern while not transmitting
        clear_lost();
        tx_active = 1'b0;
        i0 = n_ill;
        run_bit(K_RSTART, 1'b0, 1'b1, 0);
        check(n_ill - i0 == 0, "R6 idle collision ignored", n_ill - i0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule